// File: doc/BRIEF.md
# Programmable Lookup Logic Cell

This block is one logic cell of a programmable fabric. Two 3-input lookup tables, each filled from 8 configuration bits, either give two separate functions of the same three inputs, or join into one 4-input function where the fourth input picks which table answers. A third mode turns the cell into a 1-bit full adder. The adder's carry leaves the cell without a register, so neighbouring cells can be chained by logic outside the block.

The primary result passes through an optional flip-flop. The flip-flop has a clock enable and an asynchronous force input. The force drives it to 1 or to 0, chosen by a configuration bit. The primary output can also be placed on a shared local line through a tri-state driver. The 20-bit configuration word is loaded one bit per clock through a serial port. The last bit of the word appears on a serial output, so that several cells can be loaded from one chain.

Top module: `lcell_top`

## Requirements
- R1: While cfg_shift is high, each rising clock edge moves the configuration word up by one bit and puts cfg_si into bit 0. cfg_so always shows bit 19, so a word sent most significant bit first ends up in order. While cfg_shift is low, the word holds. Field layout: bits 7:0 hold table A, bits 15:8 hold table B, bits 17:16 hold the mode, bit 18 holds the force value (1 = set, 0 = clear) and bit 19 holds the bypass flag.
- R2: rst_n low clears the configuration word and the flip-flop to zero at once, without waiting for a clock.
- R3: In mode 00, and also in the spare code 11, cell_x is bit lut_in[2:0] of table A and cell_y is bit lut_in[2:0] of table B. lut_in[3] has no effect in these modes.
- R4: In mode 01, the primary function is table B's bit lut_in[2:0] when lut_in[3] is 1, and table A's bit when lut_in[3] is 0. cell_y carries the same value.
- R5: In mode 10, the primary function is lut_in[0] XOR lut_in[1] XOR carry_in. carry_out and cell_y both equal the majority of those three bits. lut_in[3:2] have no effect in this mode.
- R6: carry_out is 0 in every mode other than 10, and it is never registered.
- R7: With the bypass flag at 1, cell_x follows the primary function combinationally. With it at 0, cell_x shows the flip-flop, which loads the primary function on a rising edge when ce is 1. cell_y is always combinational.
- R8: While ce is 0, the flip-flop keeps its value across clock edges.
- R9: While sr is high, the flip-flop is forced at once to the force value. The force overrides both the clock and ce.
- R10: bus_line carries cell_x while oe is 1. While oe is 0 the cell releases the line, and another driver sets its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Asynchronous clear of configuration and flip-flop, active low |
| cfg_si | input | 1 | Serial configuration data in |
| cfg_shift | input | 1 | Shift enable for the configuration word |
| cfg_so | output | 1 | Top bit of the configuration word |
| lut_in | input | 4 | Function inputs; bit 3 is the table select in mode 01 |
| carry_in | input | 1 | Adder carry input |
| ce | input | 1 | Flip-flop clock enable |
| sr | input | 1 | Asynchronous force of the flip-flop, active high |
| oe | input | 1 | Local line drive enable |
| cell_x | output | 1 | Primary output, registered or bypassed |
| cell_y | output | 1 | Secondary combinational output |
| carry_out | output | 1 | Adder carry output |
| bus_line | inout | 1 | Shared local line, tri-state driven |

## Verification
Two cases are hard to reach from the ports. The first is the force input acting without a clock. The second is the force winning over an active clock enable on the following edge. To reach them, the stimulus raises sr shortly after one edge and samples cell_x before the next edge. It then holds sr through an edge while ce is high and the adder input would load the opposite value. It does this for both settings of the force value. The released line cannot be seen from the output alone, so the bench drives the line itself with the opposite of cell_x whenever oe is low.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

  typedef enum logic [1:0] {
    MODE_SPLIT = 2'b00,
    MODE_WIDE  = 2'b01,
    MODE_ARITH = 2'b10,
    MODE_SPARE = 2'b11
  } cell_mode_e;

  // sum bit of a one-bit adder
  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  // carry bit of a one-bit adder (majority of the three inputs)
  function automatic logic fa_carry(input logic x, input logic y, input logic ci);
    return (x & y) | (x & ci) | (y & ci);
  endfunction

endpackage

// File: rtl/lcell_cfg_chain.sv
module lcell_cfg_chain #(
  parameter int CFG_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             ser_in,
  output logic [CFG_W-1:0] cfg_word,
  output logic             ser_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_word <= '0;
    end else if (shift_en) begin
      cfg_word <= {cfg_word[CFG_W-2:0], ser_in};
    end
  end

  assign ser_out = cfg_word[CFG_W-1];

endmodule

// File: rtl/lcell_lut.sv
module lcell_lut #(
  parameter int K = 3,
  localparam int BITS = 1 << K
) (
  input  logic [BITS-1:0] tbl,
  input  logic [K-1:0]    sel,
  output logic            y
);

  assign y = tbl[sel];

endmodule

// File: rtl/lcell_func.sv
module lcell_func
  import lcell_pkg::*;
#(
  parameter int K = 3,
  localparam int BITS = 1 << K
) (
  input  logic [1:0][BITS-1:0] tables,
  input  cell_mode_e           mode,
  input  logic [K:0]           fin,
  input  logic                 carry_in,
  output logic                 prim,
  output logic                 sec,
  output logic                 carry_out
);

  logic [1:0] lut_o;

  for (genvar g = 0; g < 2; g++) begin : g_lut
    lcell_lut #(.K(K)) u_lut (
      .tbl (tables[g]),
      .sel (fin[K-1:0]),
      .y   (lut_o[g])
    );
  end

  always_comb begin
    unique case (mode)
      MODE_WIDE: begin
        prim      = fin[K] ? lut_o[1] : lut_o[0];
        sec       = prim;
        carry_out = 1'b0;
      end
      MODE_ARITH: begin
        prim      = fa_sum(fin[0], fin[1], carry_in);
        sec       = fa_carry(fin[0], fin[1], carry_in);
        carry_out = sec;
      end
      default: begin
        prim      = lut_o[0];
        sec       = lut_o[1];
        carry_out = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/lcell_ff.sv
module lcell_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic sr,
  input  logic sr_val,
  input  logic ce,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n or posedge sr) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (sr) begin
      q <= sr_val;
    end else if (ce) begin
      q <= d;
    end
  end

endmodule

// File: rtl/lcell_top.sv
module lcell_top
  import lcell_pkg::*;
#(
  parameter int K = 3,
  localparam int BITS    = 1 << K,
  localparam int CFG_W   = 2 * BITS + 4,
  localparam int MODE_LO = 2 * BITS,
  localparam int SRV_BIT = 2 * BITS + 2,
  localparam int BYP_BIT = 2 * BITS + 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_si,
  input  logic       cfg_shift,
  output logic       cfg_so,
  input  logic [K:0] lut_in,
  input  logic       carry_in,
  input  logic       ce,
  input  logic       sr,
  input  logic       oe,
  output logic       cell_x,
  output logic       cell_y,
  output logic       carry_out,
  inout  wire        bus_line
);

  logic [CFG_W-1:0]    cfg_word;
  logic [1:0][BITS-1:0] tables;
  cell_mode_e          mode_w;
  logic                sr_val_w;
  logic                bypass_w;
  logic                prim_comb;
  logic                reg_q;

  lcell_cfg_chain #(.CFG_W(CFG_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_shift),
    .ser_in   (cfg_si),
    .cfg_word (cfg_word),
    .ser_out  (cfg_so)
  );

  assign tables[0] = cfg_word[BITS-1:0];
  assign tables[1] = cfg_word[2*BITS-1:BITS];
  assign mode_w    = cell_mode_e'(cfg_word[MODE_LO+1:MODE_LO]);
  assign sr_val_w  = cfg_word[SRV_BIT];
  assign bypass_w  = cfg_word[BYP_BIT];

  lcell_func #(.K(K)) u_func (
    .tables    (tables),
    .mode      (mode_w),
    .fin       (lut_in),
    .carry_in  (carry_in),
    .prim      (prim_comb),
    .sec       (cell_y),
    .carry_out (carry_out)
  );

  lcell_ff u_ff (
    .clk    (clk),
    .rst_n  (rst_n),
    .sr     (sr),
    .sr_val (sr_val_w),
    .ce     (ce),
    .d      (prim_comb),
    .q      (reg_q)
  );

  assign cell_x   = bypass_w ? prim_comb : reg_q;
  assign bus_line = oe ? cell_x : 1'bz;

endmodule

// File: rtl/lcell_chk.sv
module lcell_chk #(
  parameter int CFG_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_shift,
  input logic             cfg_si,
  input logic [CFG_W-1:0] cfg_word,
  input logic [1:0]       mode,
  input logic             ce,
  input logic             sr,
  input logic             sr_val,
  input logic             bypass,
  input logic             d_comb,
  input logic             reg_q,
  input logic             cell_x,
  input logic             op_a,
  input logic             op_b,
  input logic             carry_in,
  input logic             carry_out
);

  a_r1_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_shift |=> cfg_word[0] == $past(cfg_si));

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_shift |=> $stable(cfg_word));

  a_r5_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |->
      carry_out == ((op_a & op_b) | (op_a & carry_in) | (op_b & carry_in)));

  a_r6_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b10) |-> !carry_out);

  a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> cell_x == d_comb);

  a_r7_reg_view: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass |-> cell_x == reg_q);

  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !sr) |=> (sr || reg_q == $past(d_comb)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && !sr) |=> (sr || $stable(reg_q)));

  a_r9_force: assert property (@(posedge clk) disable iff (!rst_n)
    sr |-> reg_q == sr_val);

endmodule

bind lcell_top lcell_chk #(.CFG_W(CFG_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_shift (cfg_shift),
  .cfg_si    (cfg_si),
  .cfg_word  (cfg_word),
  .mode      (cfg_word[MODE_LO+1:MODE_LO]),
  .ce        (ce),
  .sr        (sr),
  .sr_val    (sr_val_w),
  .bypass    (bypass_w),
  .d_comb    (prim_comb),
  .reg_q     (reg_q),
  .cell_x    (cell_x),
  .op_a      (lut_in[0]),
  .op_b      (lut_in[1]),
  .carry_in  (carry_in),
  .carry_out (carry_out)
);

// File: tb/test_lcell_top.sv
module test_lcell_top;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n, cfg_si, cfg_shift, carry_in, ce, sr, oe;
  logic [3:0] lut_in;
  logic       cfg_so, cell_x, cell_y, carry_out;
  logic       tb_en, tb_val;
  wire        bus_w;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done  = 1'b0;

  assign bus_w = tb_en ? tb_val : 1'bz;

  always #(CLK_P/2) clk = ~clk;

  lcell_top i_lcell_top (
    .clk(clk), .rst_n(rst_n), .cfg_si(cfg_si), .cfg_shift(cfg_shift),
    .cfg_so(cfg_so), .lut_in(lut_in), .carry_in(carry_in), .ce(ce),
    .sr(sr), .oe(oe), .cell_x(cell_x), .cell_y(cell_y),
    .carry_out(carry_out), .bus_line(bus_w)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // word layout: {bypass, force value, mode[1:0], table B, table A}
  function automatic logic [19:0] mk(input logic byp, input logic fv,
                                     input logic [1:0] md,
                                     input logic [7:0] tb, input logic [7:0] ta);
    return {byp, fv, md, tb, ta};
  endfunction

  task automatic load(input logic [19:0] w);
    for (int i = 19; i >= 0; i--) begin
      cfg_si    = w[i];
      cfg_shift = 1'b1;
      step();
    end
    cfg_shift = 1'b0;
    cfg_si    = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [19:0] w;
    logic [7:0]  ta, tb;
    logic        e, a, b, ci, s, cy;
    rst_n = 1'b0; cfg_si = 1'b0; cfg_shift = 1'b0; lut_in = '0;
    carry_in = 1'b0; ce = 1'b0; sr = 1'b0; oe = 1'b0;
    tb_en = 1'b1; tb_val = 1'b0;
    repeat (3) step();
    // R2: reset state
    chk("R2 cell_x", cell_x, 1'b0);
    chk("R2 cell_y", cell_y, 1'b0);
    chk("R2 carry_out", carry_out, 1'b0);
    chk("R2 cfg_so", cfg_so, 1'b0);
    rst_n = 1'b1;
    step();

    // R1: serial load order and read back through cfg_so
    w = 20'hA5C3E;
    load(w);
    chk("R1 top bit", cfg_so, w[19]);
    repeat (3) step();
    chk("R1 hold", cfg_so, w[19]);
    cfg_shift = 1'b1;
    for (int i = 18; i >= 0; i--) begin
      step();
      chk("R1 shift out", cfg_so, w[i]);
    end
    cfg_shift = 1'b0;

    // R3: split mode and spare code, lut_in[3] has no effect
    for (int p = 0; p < 4; p++) begin
      ta = (p == 0) ? 8'hE8 : (p == 1) ? 8'h3C : (p == 2) ? 8'hFF : 8'h5A;
      tb = (p == 0) ? 8'h96 : (p == 1) ? 8'h01 : (p == 2) ? 8'h80 : 8'hC3;
      load(mk(1'b1, 1'b0, (p == 3) ? 2'b11 : 2'b00, tb, ta));
      for (int v = 0; v < 16; v++) begin
        lut_in = v[3:0];
        #1;
        chk("R3 x", cell_x, ta[v % 8]);
        chk("R3 y", cell_y, tb[v % 8]);
        chk("R6 carry split", carry_out, 1'b0);
      end
    end

    // R4: combined four-input function
    ta = 8'h6A; tb = 8'hC5;
    load(mk(1'b1, 1'b0, 2'b01, tb, ta));
    for (int v = 0; v < 16; v++) begin
      lut_in = v[3:0];
      #1;
      e = (v >= 8) ? tb[v - 8] : ta[v];
      chk("R4 x", cell_x, e);
      chk("R4 y", cell_y, e);
      chk("R6 carry wide", carry_out, 1'b0);
    end

    // R5: adder, bypassed, upper inputs swept too
    load(mk(1'b1, 1'b0, 2'b10, 8'h00, 8'hFF));
    for (int v = 0; v < 32; v++) begin
      lut_in = v[3:0]; carry_in = v[4];
      #1;
      a = v[0]; b = v[1]; ci = v[4];
      s  = ((a + b + ci) % 2) == 1;
      cy = (a + b + ci) >= 2;
      chk("R5 sum", cell_x, s);
      chk("R5 carry_out", carry_out, cy);
      chk("R5 cell_y", cell_y, cy);
    end

    // R7: registered sum, carry stays combinational
    load(mk(1'b0, 1'b0, 2'b10, 8'h00, 8'h00));
    ce = 1'b1;
    for (int v = 0; v < 8; v++) begin
      lut_in = {2'b00, v[1:0]}; carry_in = v[2];
      #1;
      chk("R6 carry unregistered", carry_out, (v[0] + v[1] + v[2]) >= 2);
      step();
      chk("R7 registered sum", cell_x, ((v[0] + v[1] + v[2]) % 2) == 1);
    end

    // R8: clock enable low holds the register (last sum was 1)
    ce = 1'b0; lut_in = 4'b0011; carry_in = 1'b0;
    step(); step();
    chk("R8 hold", cell_x, 1'b1);
    ce = 1'b1;
    step();
    chk("R7 load after enable", cell_x, 1'b0);

    // R9: asynchronous set, wins over ce
    load(mk(1'b0, 1'b1, 2'b10, 8'h00, 8'h00));
    ce = 1'b1; lut_in = 4'b0000; carry_in = 1'b0;
    step();
    chk("R7 sum zero", cell_x, 1'b0);
    sr = 1'b1;
    #1;
    chk("R9 async set", cell_x, 1'b1);
    step();
    chk("R9 set beats ce", cell_x, 1'b1);
    sr = 1'b0;
    step();
    chk("R7 after set release", cell_x, 1'b0);

    // R9: asynchronous clear
    load(mk(1'b0, 1'b0, 2'b10, 8'h00, 8'h00));
    lut_in = 4'b0001;
    step();
    chk("R7 sum one", cell_x, 1'b1);
    sr = 1'b1;
    #1;
    chk("R9 async clear", cell_x, 1'b0);
    step();
    chk("R9 clear beats ce", cell_x, 1'b0);
    sr = 1'b0;
    step();
    chk("R7 after clear release", cell_x, 1'b1);

    // R10: tri-state line
    load(mk(1'b1, 1'b0, 2'b00, 8'h00, 8'h0F));
    for (int v = 0; v < 8; v += 4) begin
      lut_in = v[3:0];
      e = (v < 4);
      oe = 1'b1; tb_en = 1'b0;
      #1;
      chk("R10 driven", bus_w, e);
      oe = 1'b0; tb_en = 1'b1; tb_val = ~e;
      #1;
      chk("R10 released", bus_w, ~e);
    end
    tb_val = 1'b0;

    // R2: asynchronous reset mid-run
    load(mk(1'b0, 1'b0, 2'b10, 8'h00, 8'h00));
    lut_in = 4'b0001; ce = 1'b1;
    step();
    chk("R7 before reset", cell_x, 1'b1);
    #2;
    rst_n = 1'b0;
    #1;
    chk("R2 async clear x", cell_x, 1'b0);
    chk("R2 async clear cfg", cfg_so, 1'b0);
    step();
    rst_n = 1'b1;
    step();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule